// File: doc/BRIEF.md
# Progressive Motor Brake Ramp Sequencer

This block sits between a throttle decoder and the output stage of a small DC motor speed controller. When the decoder asks for braking, the block takes the motor drive away and applies the brake through a slow pulse-width modulated output. The brake starts gently and gets stronger at fixed intervals until it is held fully on. A run request from the decoder ends braking at once and hands the motor back to its normal drive.

Two enables pace the block, and both are made outside it. `pwm_step` advances the brake waveform by one slot, and one brake period is a fixed number of these slots. `tick_10ms` is a 10 ms timebase that counts out the interval between duty increases. Both are single-cycle enables in the block's clock domain. `brake_req` and `run_req` are single-cycle command strobes. All pins are plain control signals, with no handshake.

Top module: `brake_ramp_seq`

## Requirements
- R1: After reset, `brake_out` and `motor_zero` are both 0.
- R2: A `brake_req` strobe while idle (and without `run_req` in the same cycle) raises `brake_out` and `motor_zero` at the next clock edge, with an initial on-time of 5 slots out of 25.
- R3: While braking below full duty, `brake_out` repeats with a period of 25 `pwm_step` slots: high for the on-time, then low for 25 minus the on-time. From a fresh start, the first 4 steps keep it high, the 5th drives it low, and the 25th drives it high again.
- R4: Every 200th `tick_10ms` since braking began raises the on-time by 5 slots (20, 40, 60, 80, 100 % duty). The interval count starts from zero each time braking starts, so after 199 ticks the duty is unchanged.
- R5: At the edge where the on-time rises, the waveform restarts with `brake_out` high and a full new on-time, even if it was in its low part. This reload wins over a `pwm_step` in the same cycle.
- R6: Once the on-time is 25, `brake_out` stays high whatever `pwm_step` does, and further intervals keep it at 25.
- R7: A `run_req` strobe clears `brake_out` and `motor_zero` at the next edge. It takes priority over a `brake_req` in the same cycle.
- R8: A `brake_req` while already braking is ignored: neither the on-time nor the interval count restarts.
- R9: While idle, `pwm_step` and `tick_10ms` leave `brake_out` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| brake_req | input | 1 | Strobe: start braking |
| run_req | input | 1 | Strobe: stop braking, restore motor drive |
| pwm_step | input | 1 | Enable: advance the brake waveform one slot |
| tick_10ms | input | 1 | Enable: 10 ms timebase event |
| brake_out | output | 1 | Brake drive |
| motor_zero | output | 1 | High while braking: motor duty forced to zero |

## Verification
The assertions assume that the strobes and enables are single clock pulses sampled at the rising edge. They make no assumption about how often the strobes and enables arrive or whether they coincide, so they also cover a request landing in the same cycle as a step or an interval tick. The bench drives every input just after a falling edge and holds it for exactly one rising edge per intended event. It deliberately produces the coinciding cases (run and brake together, a brake request in the middle of the interval), and it counts duty over whole brake periods so that the result does not depend on where in the period a measurement starts.

// File: rtl/brake_ramp_pkg.sv
package brake_ramp_pkg;
  typedef enum logic {PH_LOW = 1'b0, PH_HIGH = 1'b1} phase_e;

  localparam int DEF_PERIOD   = 25;
  localparam int DEF_STEP     = 5;
  localparam int DEF_INTERVAL = 200;
endpackage

// File: rtl/brake_interval.sv
module brake_interval #(
  parameter int INTERVAL = 200,
  localparam int IW = (INTERVAL > 1) ? $clog2(INTERVAL) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic en,
  input  logic tick,
  output logic step
);
  logic [IW-1:0] cnt_q;
  logic          at_end;

  assign at_end = (cnt_q == IW'(INTERVAL - 1));
  assign step   = en && tick && at_end && !clear;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (clear)         cnt_q <= '0;
    else if (en && tick)    cnt_q <= at_end ? '0 : cnt_q + 1'b1;
  end

  assert_interval_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= IW'(INTERVAL - 1));
  assert_interval_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> cnt_q == '0);
endmodule

// File: rtl/brake_level.sv
module brake_level #(
  parameter int PERIOD = 25,
  parameter int STEP   = 5,
  localparam int CW = $clog2(PERIOD + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          raise,
  output logic [CW-1:0] on_time,
  output logic [CW-1:0] on_next
);
  assign on_next = (on_time >= CW'(PERIOD - STEP)) ? CW'(PERIOD) : on_time + CW'(STEP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      on_time <= '0;
    else if (start)  on_time <= CW'(STEP);
    else if (raise)  on_time <= on_next;
  end

  assert_level_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    on_time <= CW'(PERIOD));
  assert_level_saturate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (raise && !start && on_time == CW'(PERIOD)) |=> on_time == CW'(PERIOD));
endmodule

// File: rtl/brake_phase.sv
module brake_phase
  import brake_ramp_pkg::*;
#(
  parameter int PERIOD = 25,
  localparam int CW = $clog2(PERIOD + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          halt,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          slot,
  input  logic [CW-1:0] on_time,
  output logic          drive
);
  phase_e        ph_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_LOW;
      cnt_q <= CW'(1);
    end else if (halt) begin
      ph_q  <= PH_LOW;
      cnt_q <= CW'(1);
    end else if (load) begin
      ph_q  <= PH_HIGH;
      cnt_q <= load_val;
    end else if (run && slot) begin
      if (on_time == CW'(PERIOD)) begin
        ph_q  <= PH_HIGH;
        cnt_q <= CW'(PERIOD);
      end else if (cnt_q == CW'(1)) begin
        if (ph_q == PH_HIGH) begin
          ph_q  <= PH_LOW;
          cnt_q <= CW'(PERIOD) - on_time;
        end else begin
          ph_q  <= PH_HIGH;
          cnt_q <= on_time;
        end
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign drive = (ph_q == PH_HIGH);

  assert_slot_count_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q != '0 && cnt_q <= CW'(PERIOD));
  assert_full_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !halt && !load && drive && on_time == CW'(PERIOD)) |=> drive);
  assert_reload_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !halt) |=> drive);
endmodule

// File: rtl/brake_ramp_seq.sv
module brake_ramp_seq
  import brake_ramp_pkg::*;
#(
  parameter int PERIOD   = DEF_PERIOD,
  parameter int STEP     = DEF_STEP,
  parameter int INTERVAL = DEF_INTERVAL,
  localparam int CW = $clog2(PERIOD + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic brake_req,
  input  logic run_req,
  input  logic pwm_step,
  input  logic tick_10ms,
  output logic brake_out,
  output logic motor_zero
);
  logic          active_q;
  logic          start;
  logic          raise;
  logic          step_evt;
  logic          load;
  logic [CW-1:0] on_time;
  logic [CW-1:0] on_next;
  logic [CW-1:0] load_val;

  assign start    = brake_req && !active_q && !run_req;
  assign raise    = step_evt && !run_req;
  assign load     = start || raise;
  assign load_val = start ? CW'(STEP) : on_next;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       active_q <= 1'b0;
    else if (run_req) active_q <= 1'b0;
    else if (start)   active_q <= 1'b1;
  end

  brake_interval #(.INTERVAL(INTERVAL)) u_interval (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (start),
    .en    (active_q),
    .tick  (tick_10ms),
    .step  (step_evt)
  );

  brake_level #(.PERIOD(PERIOD), .STEP(STEP)) u_level (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .raise   (raise),
    .on_time (on_time),
    .on_next (on_next)
  );

  brake_phase #(.PERIOD(PERIOD)) u_phase (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (active_q),
    .halt     (run_req),
    .load     (load),
    .load_val (load_val),
    .slot     (pwm_step),
    .on_time  (on_time),
    .drive    (brake_out)
  );

  assign motor_zero = active_q;

  assert_entry_drives_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active_q) |-> brake_out);
  assert_run_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    run_req |=> (!brake_out && !motor_zero));
  assert_rebrake_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && brake_req && !run_req) |=> on_time >= $past(on_time));
  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !active_q |-> !brake_out);
endmodule

// File: tb/tb_brake_ramp_seq.sv
`timescale 1ns/1ps
module tb_brake_ramp_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic brake_req = 1'b0;
  logic run_req = 1'b0;
  logic pwm_step = 1'b0;
  logic tick_10ms = 1'b0;
  logic brake_out;
  logic motor_zero;
  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  brake_ramp_seq dut (
    .clk(clk), .rst_n(rst_n), .brake_req(brake_req), .run_req(run_req),
    .pwm_step(pwm_step), .tick_10ms(tick_10ms),
    .brake_out(brake_out), .motor_zero(motor_zero)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic strobe_brake();
    brake_req = 1'b1; @(negedge clk); brake_req = 1'b0;
  endtask

  task automatic strobe_run();
    run_req = 1'b1; @(negedge clk); run_req = 1'b0;
  endtask

  task automatic ticks(input int n);
    tick_10ms = 1'b1;
    repeat (n) @(negedge clk);
    tick_10ms = 1'b0;
  endtask

  task automatic highs(input int n, output int cnt);
    cnt = 0;
    pwm_step = 1'b1;
    repeat (n) begin
      @(negedge clk);
      if (brake_out) cnt++;
    end
    pwm_step = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 brake_out", brake_out, 0);
    check("R1 motor_zero", motor_zero, 0);
  endtask

  task automatic t_idle();
    int bad = 0;
    pwm_step = 1'b1; tick_10ms = 1'b1;
    repeat (300) begin
      @(negedge clk);
      if (brake_out) bad++;
    end
    pwm_step = 1'b0; tick_10ms = 1'b0;
    check("R9 idle highs", bad, 0);
  endtask

  task automatic t_entry();
    int bad = 0;
    strobe_brake();
    check("R2 brake_out", brake_out, 1);
    check("R2 motor_zero", motor_zero, 1);
    pwm_step = 1'b1;
    for (int k = 1; k <= 25; k++) begin
      @(negedge clk);
      if (int'(brake_out) != int'(k < 5 || k == 25)) bad++;
    end
    pwm_step = 1'b0;
    check("R3 waveform mismatches", bad, 0);
  endtask

  task automatic t_step();
    int h;
    pwm_step = 1'b1; repeat (8) @(negedge clk); pwm_step = 1'b0;
    check("R3 low part", brake_out, 0);
    ticks(199);
    check("R4 no early step", brake_out, 0);
    ticks(1);
    check("R5 reload high", brake_out, 1);
    highs(50, h);
    check("R4 duty 40", h, 20);
  endtask

  task automatic t_ignore();
    int h;
    ticks(100);
    strobe_brake();
    check("R8 still braking", motor_zero, 1);
    ticks(100);
    highs(50, h);
    check("R8 duty 60 no restart", h, 30);
  endtask

  task automatic t_full();
    int h;
    ticks(200);
    highs(50, h);
    check("R4 duty 80", h, 40);
    ticks(200);
    highs(60, h);
    check("R6 full on", h, 60);
    ticks(400);
    highs(50, h);
    check("R6 saturated", h, 50);
  endtask

  task automatic t_run();
    int h;
    strobe_run();
    check("R7 brake_out", brake_out, 0);
    check("R7 motor_zero", motor_zero, 0);
    highs(50, h);
    check("R7 stays off", h, 0);
  endtask

  task automatic t_rebrake();
    int h;
    strobe_brake();
    check("R2 restart", brake_out, 1);
    ticks(150);
    strobe_run();
    strobe_brake();
    ticks(199);
    highs(50, h);
    check("R4 interval from zero duty 20", h, 10);
  endtask

  task automatic t_simul();
    brake_req = 1'b1; run_req = 1'b1; @(negedge clk);
    brake_req = 1'b0; run_req = 1'b0;
    check("R7 both while braking", motor_zero, 0);
    brake_req = 1'b1; run_req = 1'b1; @(negedge clk);
    brake_req = 1'b0; run_req = 1'b0;
    check("R7 both while idle", brake_out, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_idle();
    t_entry();
    t_step();
    t_ignore();
    t_full();
    t_run();
    t_rebrake();
    t_simul();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL R1-watchdog actual=timeout expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule